// File: doc/BRIEF.md
# Three-Stage Prescaled Watchdog

This block is a single watchdog channel with escalation. Software programs one 64-bit configuration word: a two-bit mode, a reload length and two stop enables. The channel then counts a down-counter toward zero. The down-counter steps once every 2^PRESC_LOG2 clocks, and a reload places the length in its top bits. Each time the counter runs out, the channel moves to the next stage. The first timeout raises a first interrupt, the second a second interrupt, and the third a reset request. The mode decides how far the escalation may go. Software keeps the channel alive with a poke write, which restarts the current countdown and returns the channel to stage 0.

The counting can be frozen while a debug-halt or system-halt input is high, each only if its own stop enable is set. The reset request is terminal: once raised, it stays high and the channel ignores software until the block is reset.

Control is a four-state machine. OFF is the disabled state. RUN is counting. HOLD means escalation stopped at the mode's limit. TRIPPED means the reset request has been raised. The transitions are:
- enable: OFF to RUN, on a configuration write with a non-zero mode.
- disable: RUN or HOLD to OFF, on a configuration write with mode 0.
- restart: RUN or HOLD to RUN, on a poke or on a configuration write with a non-zero mode.
- escalate: RUN to RUN, on a timeout below the mode's limit.
- park: RUN to HOLD, on a timeout that reaches stage 1 in mode 1 or stage 2 in mode 2.
- trip: RUN to TRIPPED, on the third timeout.

Top module: `wdog_escalate`

## Requirements
- R1: Read-back layout of the configuration word:
  - mode at [1:0]
  - stage at [3:2]
  - length at [LEN_W+3:4]
  - live counter in the next CNT_W bits
  - debug-stop enable in the next bit, then global-stop enable; with the defaults these are [19:4], [43:20], bit 44 and bit 45.
  - All other bits read 0. The written stage and counter fields are ignored.
- R2: After reset the configuration word reads 0, the state is OFF, and irq_first, irq_second and reset_req are low.
- R3: An accepted configuration write has these effects:
  - it stores mode, length and both stop enables;
  - it sets the stage to 0 and loads the counter with length << (CNT_W-LEN_W);
  - it clears the prescaler and both interrupts.
- R4: While the channel is running, the counter decrements once every 2^PRESC_LOG2 clocks. A stage times out (L*2^(CNT_W-LEN_W)+1)*2^PRESC_LOG2 clock edges after the edge that loaded it, where L is the length.
- R5: A timeout advances the stage. From stage 0 it raises irq_first, from stage 1 it raises irq_second, and from stage 2 it raises reset_req, reaching stage 3. The interrupts stay high until a poke or a configuration write.
- R6: A timeout that does not end escalation reloads the counter from the length, and the next stage lasts as long as the first.
- R7: Mode 1 stops at stage 1 and mode 2 stops at stage 2 (HOLD), with the counter held at 0. Mode 3 runs on to the reset request.
- R8: Mode 0 disables the channel: the counter stays still and nothing times out. A write of all zeros disables it. The channel runs whenever mode is non-zero.
- R9: A poke reloads the counter from the length, sets the stage to 0, clears both interrupts and the prescaler, and moves HOLD back to RUN.
- R10: A poke or configuration write in the same cycle as a timeout wins: the timeout is discarded.
- R11: With the debug-stop bit set, dbg_halt freezes the prescaler and the counter. With the global-stop bit set, sys_halt does the same. With the stop bit clear, the matching input has no effect.
- R12: reset_req stays high until rst_n. In TRIPPED, pokes and configuration writes have no effect.
- R13: A configuration write and a poke in the same cycle act as the configuration write alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 64 | Configuration write data |
| poke_we | input | 1 | Poke write strobe (data ignored) |
| dbg_halt | input | 1 | Debug halt request |
| sys_halt | input | 1 | Global halt request |
| cfg_rdata | output | 64 | Configuration word read-back |
| irq_first | output | 1 | First-stage interrupt, level |
| irq_second | output | 1 | Second-stage interrupt, level |
| reset_req | output | 1 | Soft-reset request, sticky |

## Verification
A poke or a configuration write can land in the very cycle in which the counter's final step would time out the stage. The bench configures a small channel and counts edges to the exact timeout edge. It then drives the poke, or a new configuration, so that it is sampled on that edge. The result counts as correct only if no interrupt rises, the stage reads 0 and the counter reads the reload value. The next timeout must then arrive a full stage period after the poke edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_OFF     = 2'd0,
        WD_RUN     = 2'd1,
        WD_HOLD    = 2'd2,
        WD_TRIPPED = 2'd3
    } wd_state_e;
endpackage

// File: rtl/wd_tick_gen.sv
module wd_tick_gen #(
    parameter int PRESC_LOG2 = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run_en,
    output logic tick
);
    localparam logic [PRESC_LOG2-1:0] LAST = '1;

    logic [PRESC_LOG2-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_q <= '0;
        else if (clr)
            pre_q <= '0;
        else if (run_en)
            pre_q <= pre_q + PRESC_LOG2'(1);
    end

    assign tick = run_en && !clr && (pre_q == LAST);

    // R4: prescaler advances by one per enabled clock
    assert_pre_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && !clr) |=> (pre_q == $past(pre_q) + PRESC_LOG2'(1)));
    // R9: clear returns the prescaler to zero
    assert_pre_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_q == '0));
endmodule

// File: rtl/wd_down_counter.sv
module wd_down_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);

    // R4: one step down per prescaled tick
    assert_cnt_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
    // R8: no tick and no load leaves the counter unchanged
    assert_cnt_still_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/wd_stage_fsm.sv
module wd_stage_fsm
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc_cfg,
    input  logic       acc_poke,
    input  logic [1:0] new_mode,
    input  logic [1:0] mode_q,
    input  logic       expire,
    output wd_state_e  state,
    output logic [1:0] stage,
    output logic       reload_exp,
    output logic       irq_first,
    output logic       irq_second,
    output logic       reset_req
);
    wd_state_e  state_q, state_d;
    logic [1:0] stage_q;
    logic [1:0] nxt_stage;
    logic       run_expire;

    assign nxt_stage  = stage_q + 2'd1;
    assign run_expire = (state_q == WD_RUN) && expire && !acc_cfg && !acc_poke;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= WD_OFF;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d    = state_q;
        reload_exp = 1'b0;
        unique case (state_q)
            WD_OFF: begin
                if (acc_cfg && new_mode != 2'd0)
                    state_d = WD_RUN;
            end
            WD_RUN, WD_HOLD: begin
                if (acc_cfg)
                    state_d = (new_mode == 2'd0) ? WD_OFF : WD_RUN;
                else if (acc_poke)
                    state_d = WD_RUN;
                else if (run_expire) begin
                    if (nxt_stage == 2'd3)
                        state_d = WD_TRIPPED;
                    else if (nxt_stage == mode_q)
                        state_d = WD_HOLD;
                    else begin
                        state_d    = WD_RUN;
                        reload_exp = 1'b1;
                    end
                end
            end
            WD_TRIPPED: state_d = WD_TRIPPED;
            default:    state_d = WD_OFF;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q    <= 2'd0;
            irq_first  <= 1'b0;
            irq_second <= 1'b0;
            reset_req  <= 1'b0;
        end else if (acc_cfg || acc_poke) begin
            stage_q    <= 2'd0;
            irq_first  <= 1'b0;
            irq_second <= 1'b0;
        end else if (run_expire) begin
            stage_q <= nxt_stage;
            if (stage_q == 2'd0) irq_first  <= 1'b1;
            if (stage_q == 2'd1) irq_second <= 1'b1;
            if (stage_q == 2'd2) reset_req  <= 1'b1;
        end
    end

    assign state = state_q;
    assign stage = stage_q;

    // R12: reset request is sticky
    assert_reset_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> reset_req);
    // R5: reset request only at the final stage
    assert_reset_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (stage_q == 2'd3));
    // R5: second interrupt implies the first is still raised
    assert_irq_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_second |-> irq_first);
    // R9: poke returns to stage 0 with interrupts low
    assert_poke_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_poke |=> (stage_q == 2'd0 && !irq_first && !irq_second));
    // R8: disabled channel sits at stage 0
    assert_off_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WD_OFF) |-> (stage_q == 2'd0));
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
    import wdog_pkg::*;
#(
    parameter int PRESC_LOG2 = 10,
    parameter int LEN_W      = 16,
    parameter int CNT_W      = 24
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [63:0] cfg_wdata,
    input  logic        poke_we,
    input  logic        dbg_halt,
    input  logic        sys_halt,
    output logic [63:0] cfg_rdata,
    output logic        irq_first,
    output logic        irq_second,
    output logic        reset_req
);
    localparam int LEN_LO    = 4;
    localparam int CNT_LO    = LEN_LO + LEN_W;
    localparam int DSTOP_BIT = CNT_LO + CNT_W;
    localparam int GSTOP_BIT = DSTOP_BIT + 1;
    localparam int SHIFT     = CNT_W - LEN_W;

    wd_state_e        state;
    logic [1:0]       stage;
    logic [1:0]       mode_q;
    logic [LEN_W-1:0] len_q;
    logic             dstop_q, gstop_q;
    logic             acc_cfg, acc_poke, halt, run_en, tick, expire, reload_exp;
    logic             cnt_load, cnt_zero;
    logic [LEN_W-1:0] len_src;
    logic [CNT_W-1:0] cnt, load_val;
    logic             unused_wdata;

    assign acc_cfg  = cfg_we && (state != WD_TRIPPED);
    assign acc_poke = poke_we && !cfg_we && (state != WD_TRIPPED);
    assign halt     = (dstop_q && dbg_halt) || (gstop_q && sys_halt);
    assign run_en   = (state == WD_RUN) && !halt;
    assign expire   = tick && cnt_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q  <= 2'd0;
            len_q   <= '0;
            dstop_q <= 1'b0;
            gstop_q <= 1'b0;
        end else if (acc_cfg) begin
            mode_q  <= cfg_wdata[1:0];
            len_q   <= cfg_wdata[CNT_LO-1:LEN_LO];
            dstop_q <= cfg_wdata[DSTOP_BIT];
            gstop_q <= cfg_wdata[GSTOP_BIT];
        end
    end

    assign len_src  = acc_cfg ? cfg_wdata[CNT_LO-1:LEN_LO] : len_q;
    assign load_val = CNT_W'(len_src) << SHIFT;
    assign cnt_load = acc_cfg || acc_poke || reload_exp;

    wd_tick_gen #(.PRESC_LOG2(PRESC_LOG2)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_cfg || acc_poke),
        .run_en (run_en),
        .tick   (tick)
    );

    wd_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (load_val),
        .tick     (tick),
        .cnt      (cnt),
        .zero     (cnt_zero)
    );

    wd_stage_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_cfg    (acc_cfg),
        .acc_poke   (acc_poke),
        .new_mode   (cfg_wdata[1:0]),
        .mode_q     (mode_q),
        .expire     (expire),
        .state      (state),
        .stage      (stage),
        .reload_exp (reload_exp),
        .irq_first  (irq_first),
        .irq_second (irq_second),
        .reset_req  (reset_req)
    );

    always_comb begin
        cfg_rdata                       = '0;
        cfg_rdata[1:0]                  = mode_q;
        cfg_rdata[3:2]                  = stage;
        cfg_rdata[CNT_LO-1:LEN_LO]      = len_q;
        cfg_rdata[DSTOP_BIT-1:CNT_LO]   = cnt;
        cfg_rdata[DSTOP_BIT]            = dstop_q;
        cfg_rdata[GSTOP_BIT]            = gstop_q;
    end

    assign unused_wdata = ^{cfg_wdata[3:2], cfg_wdata[DSTOP_BIT-1:CNT_LO],
                            cfg_wdata[63:GSTOP_BIT+1]};

    // R11: an enabled halt freezes the live counter
    assert_halt_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !cnt_load) |=> $stable(cnt));
    // R12: tripped channel ignores configuration writes
    assert_tripped_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_TRIPPED) |=> $stable(mode_q) && $stable(len_q));
    // R8: mode field is zero exactly when the channel is off
    assert_off_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_OFF) |-> (mode_q == 2'd0));
endmodule

// File: tb/tb_wdog_escalate.sv
`timescale 1ns/1ps
module tb_wdog_escalate;
    localparam int PL = 2;
    localparam int LW = 4;
    localparam int CW = 6;
    localparam int P  = 1 << PL;
    localparam int S  = 1 << (CW - LW);
    localparam int CL = 4 + LW;
    localparam int DS = CL + CW;
    localparam int GS = DS + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, poke_we = 1'b0, dbg_halt = 1'b0, sys_halt = 1'b0;
    logic [63:0] cfg_wdata = '0;
    logic [63:0] cfg_rdata;
    logic        irq_first, irq_second, reset_req;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    wdog_escalate #(.PRESC_LOG2(PL), .LEN_W(LW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .poke_we(poke_we), .dbg_halt(dbg_halt), .sys_halt(sys_halt),
        .cfg_rdata(cfg_rdata), .irq_first(irq_first), .irq_second(irq_second),
        .reset_req(reset_req)
    );

    function automatic int tmo(int l);
        return (l * S + 1) * P;
    endfunction

    function automatic logic [63:0] mk(int mode, int len, bit ds, bit gs);
        logic [63:0] w = '0;
        w[1:0]     = 2'(mode);
        w[CL-1:4]  = LW'(len);
        w[DS]      = ds;
        w[GS]      = gs;
        return w;
    endfunction

    function automatic int f_mode();  return int'(cfg_rdata[1:0]);    endfunction
    function automatic int f_stage(); return int'(cfg_rdata[3:2]);    endfunction
    function automatic int f_cnt();   return int'(cfg_rdata[DS-1:CL]); endfunction

    task automatic chk(string tag, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [63:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic poke();
        @(negedge clk);
        poke_we = 1'b1;
        @(posedge clk); #1;
        poke_we = 1'b0;
    endtask

    task automatic edges(int k);
        for (int i = 0; i < k; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic wait_sig(int sel, output int n);
        n = 0;
        while (n < 2000) begin
            if (sel == 0 && irq_first)  break;
            if (sel == 1 && irq_second) break;
            if (sel == 2 && reset_req)  break;
            @(posedge clk); #1;
            n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        #1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, c0;
        logic [63:0] w, expw;
        do_reset();
        // R2 reset state
        chk("R2 rdata", cfg_rdata, 0);
        chk("R2 irq", {irq_first, irq_second, reset_req}, 0);

        // R1 / R3 layout, ignored stage and counter fields
        w = mk(1, 5, 1, 1); w[3:2] = 2'b11; w[DS-1:CL] = '1; w[63] = 1'b1;
        wr(w);
        expw = mk(1, 5, 1, 1); expw[DS-1:CL] = CW'(5 * S);
        chk("R1 readback", cfg_rdata, expw);
        chk("R3 stage cleared", f_stage(), 0);
        wr('0);
        chk("R8 all-zero disable", cfg_rdata, 0);

        // R4 step rate
        wr(mk(1, 3, 0, 0));
        edges(P - 1);
        chk("R4 no step before prescale", f_cnt(), 3 * S);
        edges(1);
        chk("R4 one step", f_cnt(), 3 * S - 1);
        wr('0);

        // R4/R5/R7/R9 sweep of all lengths in mode 1
        for (int l = 0; l < (1 << LW); l++) begin
            wr(mk(1, l, 0, 0));
            chk("R3 load", f_cnt(), l * S);
            wait_sig(0, n);
            chk("R4 timeout", n, tmo(l));
            chk("R5 stage1", f_stage(), 1);
            edges(2 * tmo(l) + 4);
            chk("R7 mode1 no second", irq_second, 0);
            chk("R7 mode1 hold cnt", f_cnt(), 0);
            poke();
            chk("R9 poke irq", irq_first, 0);
            chk("R9 poke cnt", f_cnt() + 64 * f_stage(), l * S);
            wait_sig(0, n);
            chk("R9 restart from hold", n, tmo(l));
            wr('0);
        end

        // R5/R6 mode 3 full escalation, R12 lock
        wr(mk(3, 2, 0, 0));
        wait_sig(0, n); chk("R5 first", n, tmo(2));
        chk("R6 reload", f_cnt(), 2 * S);
        wait_sig(1, n); chk("R6 second period", n, tmo(2));
        chk("R5 first held", irq_first, 1);
        chk("R5 stage2", f_stage(), 2);
        wait_sig(2, n); chk("R5 reset period", n, tmo(2));
        chk("R5 stage3", f_stage(), 3);
        poke();
        wr(mk(1, 1, 0, 0));
        edges(50);
        chk("R12 reset held", reset_req, 1);
        chk("R12 mode locked", f_mode(), 3);
        chk("R12 stage locked", f_stage(), 3);
        do_reset();
        chk("R12 cleared by reset", reset_req, 0);
        chk("R2 rdata after reset", cfg_rdata, 0);

        // R7 mode 2
        wr(mk(2, 1, 0, 0));
        wait_sig(0, n); chk("R7 m2 first", n, tmo(1));
        wait_sig(1, n); chk("R7 m2 second", n, tmo(1));
        edges(100);
        chk("R7 m2 no reset", reset_req, 0);
        chk("R7 m2 stage", f_stage(), 2);
        wr('0);
        chk("R3 cfg clears irq", {irq_first, irq_second}, 0);

        // R8 disable
        wr(mk(1, 2, 0, 0)); edges(10); wr('0); edges(200);
        chk("R8 no timeout", irq_first, 0);
        wr(mk(0, 3, 0, 0)); edges(100);
        chk("R8 mode0 still", f_cnt(), 3 * S);
        chk("R8 mode0 no irq", irq_first, 0);

        // R9 poke mid-count
        wr(mk(1, 3, 0, 0)); edges(30); poke();
        wait_sig(0, n); chk("R9 poke restart", n, tmo(3));
        wr('0);

        // R10 poke on timeout edge
        wr(mk(1, 2, 0, 0)); edges(tmo(2) - 1); poke();
        chk("R10 poke wins irq", irq_first, 0);
        chk("R10 poke wins stage", f_stage(), 0);
        chk("R10 poke wins cnt", f_cnt(), 2 * S);
        wait_sig(0, n); chk("R10 full period after", n, tmo(2));
        // R10 config write on timeout edge
        wr(mk(1, 2, 0, 0)); edges(tmo(2) - 1); wr(mk(1, 1, 0, 0));
        chk("R10 cfg wins irq", irq_first, 0);
        chk("R10 cfg wins cnt", f_cnt(), S);
        wr('0);

        // R13 both strobes together
        wr(mk(1, 3, 0, 0)); edges(7);
        @(negedge clk); cfg_we = 1'b1; poke_we = 1'b1; cfg_wdata = mk(3, 1, 0, 0);
        @(posedge clk); #1; cfg_we = 1'b0; poke_we = 1'b0;
        chk("R13 mode", f_mode(), 3);
        chk("R13 cnt", f_cnt(), S);
        wr('0);

        // R11 halts
        wr(mk(1, 2, 1, 0)); edges(5);
        c0 = f_cnt(); dbg_halt = 1'b1; edges(20);
        chk("R11 dbg frozen", f_cnt(), c0);
        dbg_halt = 1'b0;
        wait_sig(0, n); chk("R11 dbg delay", n + 25, tmo(2) + 20);
        wr(mk(1, 2, 0, 1)); edges(5);
        sys_halt = 1'b1; edges(13); sys_halt = 1'b0;
        wait_sig(0, n); chk("R11 sys delay", n + 18, tmo(2) + 13);
        wr(mk(1, 2, 0, 0)); edges(5);
        dbg_halt = 1'b1; sys_halt = 1'b1; edges(13); dbg_halt = 1'b0; sys_halt = 1'b0;
        wait_sig(0, n); chk("R11 stop bits clear", n + 18, tmo(2));
        wr('0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule